// File: doc/BRIEF.md
# Bidirectional Octal Latched Transceiver

This block moves a byte between two ports, A and B, in either direction without inverting it. Each direction owns a bank of storage bits and three active-low controls: a direction enable, a latch enable and an output enable. With the direction enabled and its latch enable low, the bank is transparent and the far port's output follows the near port's input in the same cycle. When the latch enable or the direction enable goes high, the bank holds the last value it sampled and ignores further input changes.

For use inside a synchronous chip, each port is split into an input vector, an output vector and a per-bit output-enable vector, so that a pad ring or a bus wrapper can build the tri-state driver. The storage banks are clocked registers that sample the near-side input at every rising clock edge while transparent. A synchronous reset clears both banks. A contention flag reports when both directions drive at once, so that each port is driven by the block while also being read as the other path's input.

Top module: `octal_latch_xcvr`

## Requirements
- R1: A clock edge with `rst` high clears both storage banks to zero, so a held output reads 0x00 in the cycle after reset is released.
- R2: With `ce_ab_n` and `le_ab_n` both low, `b_out` equals `a_in` bit for bit (no inversion) in the same cycle, with no clock edge in between.
- R3: When the A-to-B bank leaves the transparent state, `b_out` shows the `a_in` value sampled at the last rising clock edge at which `ce_ab_n` and `le_ab_n` were both low.
- R4: While `ce_ab_n` or `le_ab_n` is high, `b_out` keeps its stored value whatever `a_in` does.
- R5: While `ce_ab_n` is high, every bit of `b_oe` is 0, whatever `le_ab_n` and `oe_ab_n` are.
- R6: Every bit of `b_oe` is 1 exactly when `ce_ab_n` and `oe_ab_n` are both low. A high `oe_ab_n` hides the data on `b_out` but does not stop the bank from tracking or holding.
- R7: The B-to-A path behaves like R2 to R6 with `ce_ba_n`, `le_ba_n`, `oe_ba_n`, `b_in`, `a_out` and `a_oe`, and neither path's controls affect the other path.
- R8: `contention` is 1 exactly when both `a_oe` and `b_oe` are enabled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; banks sample on the rising edge |
| rst | input | 1 | Synchronous reset, active high, clears both banks |
| ce_ab_n | input | 1 | A-to-B direction enable, active low |
| le_ab_n | input | 1 | A-to-B latch enable, active low (low = transparent) |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| ce_ba_n | input | 1 | B-to-A direction enable, active low |
| le_ba_n | input | 1 | B-to-A latch enable, active low (low = transparent) |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| a_in | input | WIDTH | Data read from port A |
| a_out | output | WIDTH | Data offered to port A by the B-to-A path |
| a_oe | output | WIDTH | Per-bit drive enable for port A |
| b_in | input | WIDTH | Data read from port B |
| b_out | output | WIDTH | Data offered to port B by the A-to-B path |
| b_oe | output | WIDTH | Per-bit drive enable for port B |
| contention | output | 1 | Both directions are driving at the same time |

## Verification
The output-enable vectors, the contention flag and the transparent data path are combinational, so their effect is due in the same cycle the controls or input change; captured values appear in the first cycle after the clock edge that sampled them, and reset takes effect from the cycle after a reset edge. The bench changes inputs on the falling clock edge, compares all outputs a short delay later against a behavioural model, and updates the model's stored bytes only at the rising edge, exactly where the design's banks move.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // State of one direction's storage bank
   typedef enum logic [1:0] {
      LAT_HOLD = 2'd0,
      LAT_PASS = 2'd1
   } lat_mode_e;

   // The three active-low controls of one direction
   typedef struct packed {
      logic ce_n;
      logic le_n;
      logic oe_n;
   } dir_ctl_t;

endpackage

// File: rtl/xcvr_dir_decode.sv
module xcvr_dir_decode
   import xcvr_pkg::*;
(
   input  dir_ctl_t  ctl,
   output lat_mode_e mode,
   output logic      drive
);

   // Direction enable gates both the latch path and the output path
   always_comb begin
      if (!ctl.ce_n && !ctl.le_n) begin
         mode = LAT_PASS;
      end else begin
         mode = LAT_HOLD;
      end
      drive = !ctl.ce_n && !ctl.oe_n;
   end

endmodule

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank
   import xcvr_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter bit          HAS_RESET = 1'b1,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  lat_mode_e        mode,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] store;
   logic             pass;

   assign pass = (mode == LAT_PASS);

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (HAS_RESET) begin : g_rst
            always_ff @(posedge clk) begin
               if (rst) begin
                  store[i] <= RESET_VAL[i];
               end else if (pass) begin
                  store[i] <= din[i];
               end
            end
         end else begin : g_norst
            always_ff @(posedge clk) begin
               if (pass) begin
                  store[i] <= din[i];
               end
            end
         end
         // Transparent view: current input while open, stored bit otherwise
         assign dout[i] = pass ? din[i] : store[i];
      end
   endgenerate

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
   import xcvr_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter bit          HAS_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  dir_ctl_t         ctl,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic [WIDTH-1:0] oe,
   output logic             drive
);

   lat_mode_e mode;

   xcvr_dir_decode u_dec (
      .ctl   (ctl),
      .mode  (mode),
      .drive (drive)
   );

   xcvr_latch_bank #(
      .WIDTH     (WIDTH),
      .HAS_RESET (HAS_RESET),
      .RESET_VAL ('0)
   ) u_bank (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .din  (din),
      .dout (dout)
   );

   assign oe = {WIDTH{drive}};

   // R2
   pass_through_chk: assert property (@(posedge clk) disable iff (rst)
      (!ctl.ce_n && !ctl.le_n) |-> (dout == din));

   // R3
   capture_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(ctl.ce_n) && !$past(ctl.le_n) && (ctl.ce_n || ctl.le_n))
      |-> (dout == $past(din)));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(ctl.ce_n) || $past(ctl.le_n)) && (ctl.ce_n || ctl.le_n))
      |-> $stable(dout));

   // R5
   disabled_chk: assert property (@(posedge clk) disable iff (rst)
      ctl.ce_n |-> (oe == '0));

   // R6
   enabled_chk: assert property (@(posedge clk) disable iff (rst)
      (!ctl.ce_n && !ctl.oe_n) |-> (&oe));

endmodule

// File: rtl/octal_latch_xcvr.sv
module octal_latch_xcvr
   import xcvr_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter bit          HAS_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ce_ab_n,
   input  logic             le_ab_n,
   input  logic             oe_ab_n,
   input  logic             ce_ba_n,
   input  logic             le_ba_n,
   input  logic             oe_ba_n,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe,
   output logic             contention
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("octal_latch_xcvr: WIDTH must be at least 1");
      end
   endgenerate

   dir_ctl_t ctl_ab;
   dir_ctl_t ctl_ba;
   logic     drv_ab;
   logic     drv_ba;

   assign ctl_ab = '{ce_n: ce_ab_n, le_n: le_ab_n, oe_n: oe_ab_n};
   assign ctl_ba = '{ce_n: ce_ba_n, le_n: le_ba_n, oe_n: oe_ba_n};

   // A-to-B path: reads A, offers data to B
   xcvr_path #(
      .WIDTH     (WIDTH),
      .HAS_RESET (HAS_RESET)
   ) u_ab (
      .clk   (clk),
      .rst   (rst),
      .ctl   (ctl_ab),
      .din   (a_in),
      .dout  (b_out),
      .oe    (b_oe),
      .drive (drv_ab)
   );

   // B-to-A path: reads B, offers data to A
   xcvr_path #(
      .WIDTH     (WIDTH),
      .HAS_RESET (HAS_RESET)
   ) u_ba (
      .clk   (clk),
      .rst   (rst),
      .ctl   (ctl_ba),
      .din   (b_in),
      .dout  (a_out),
      .oe    (a_oe),
      .drive (drv_ba)
   );

   assign contention = drv_ab && drv_ba;

   // R8
   contention_set_chk: assert property (@(posedge clk) disable iff (rst)
      contention |-> ((|a_oe) && (|b_oe)));

   // R8
   contention_miss_chk: assert property (@(posedge clk) disable iff (rst)
      ((|a_oe) && (|b_oe)) |-> contention);

   // R7
   ba_disabled_chk: assert property (@(posedge clk) disable iff (rst)
      ce_ba_n |-> (a_oe == '0));

endmodule

// File: tb/tb_octal_latch_xcvr.sv
module tb_octal_latch_xcvr;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic         ce_ab_n, le_ab_n, oe_ab_n;
   logic         ce_ba_n, le_ba_n, oe_ba_n;
   logic [W-1:0] a_in, b_in;
   logic [W-1:0] a_out, a_oe, b_out, b_oe;
   logic         contention;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // Behavioural model state: last captured byte per direction
   logic [W-1:0] m_ab;
   logic [W-1:0] m_ba;

   always #10 clk = ~clk;

   octal_latch_xcvr #(.WIDTH(W), .HAS_RESET(1'b1)) dut (
      .clk(clk), .rst(rst),
      .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
      .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
      .contention(contention)
   );

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare every output against the model for the current inputs
   task automatic compare();
      logic [W-1:0] e_b, e_a, e_boe, e_aoe;
      logic         e_c;
      e_b   = (!ce_ab_n && !le_ab_n) ? a_in : m_ab;
      e_a   = (!ce_ba_n && !le_ba_n) ? b_in : m_ba;
      e_boe = (!ce_ab_n && !oe_ab_n) ? '1 : '0;
      e_aoe = (!ce_ba_n && !oe_ba_n) ? '1 : '0;
      e_c   = (e_boe != 0) && (e_aoe != 0);
      if (!ce_ab_n && !le_ab_n) chk(b_out === e_b, "R2 b_out", b_out, e_b);
      else                      chk(b_out === e_b, "R4 b_out", b_out, e_b);
      if (ce_ab_n) chk(b_oe === e_boe, "R5 b_oe", b_oe, e_boe);
      else         chk(b_oe === e_boe, "R6 b_oe", b_oe, e_boe);
      chk(a_out === e_a, "R7 a_out", a_out, e_a);
      chk(a_oe === e_aoe, "R7 a_oe", a_oe, e_aoe);
      chk(contention === e_c, "R8 contention", {7'd0, contention}, {7'd0, e_c});
   endtask

   // One cycle: inputs were set after a falling edge
   task automatic cyc();
      #2 compare();
      @(posedge clk);
      if (rst) begin
         m_ab = '0;
         m_ba = '0;
      end else begin
         if (!ce_ab_n && !le_ab_n) m_ab = a_in;
         if (!ce_ba_n && !le_ba_n) m_ba = b_in;
      end
      @(negedge clk);
   endtask

   task automatic set_ab(input logic ce, input logic le, input logic oe);
      ce_ab_n = ce; le_ab_n = le; oe_ab_n = oe;
   endtask

   task automatic set_ba(input logic ce, input logic le, input logic oe);
      ce_ba_n = ce; le_ba_n = le; oe_ba_n = oe;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      m_ab = 'x; m_ba = 'x;
      rst = 1'b1;
      set_ab(1, 1, 1); set_ba(1, 1, 1);
      a_in = '0; b_in = '0;
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         m_ab = '0; m_ba = '0;
         @(negedge clk);
      end
      rst = 1'b0;

      // R1: both banks read zero while holding and driving
      set_ab(0, 1, 0); set_ba(0, 1, 1);
      a_in = 8'hC3; b_in = 8'h3C;
      #2;
      chk(b_out === 8'h00, "R1 b_out after reset", b_out, 8'h00);
      chk(a_out === 8'h00, "R1 a_out after reset", a_out, 8'h00);
      cyc();

      // R2: transparent A-to-B with several patterns
      set_ab(0, 0, 0);
      foreach (lfsr[i]) begin end
      a_in = 8'h5A; cyc();
      a_in = 8'hA5; cyc();
      a_in = 8'hFF; cyc();
      a_in = 8'h00; cyc();
      a_in = 8'h3C; cyc();

      // R3: capture when latch enable rises
      set_ab(0, 1, 0);
      a_in = 8'h81;
      #2 chk(b_out === 8'h3C, "R3 capture on le rise", b_out, 8'h3C);
      cyc();
      // R4: stored value survives input changes
      a_in = 8'h7E; cyc();
      a_in = 8'h18; cyc();

      // R3: capture when direction enable rises; R5 outputs off
      set_ab(0, 0, 0); a_in = 8'h96; cyc();
      set_ab(1, 0, 0); a_in = 8'h11; cyc();
      set_ab(1, 1, 0); a_in = 8'h22; cyc();
      set_ab(0, 1, 0);
      #2 chk(b_out === 8'h96, "R3 capture on ce rise", b_out, 8'h96);
      cyc();

      // R6: output disabled while bank tracks
      set_ab(0, 0, 1); a_in = 8'h77; cyc();
      a_in = 8'h66; cyc();
      set_ab(0, 1, 0); a_in = 8'h00;
      #2 chk(b_out === 8'h66, "R6 tracked while hidden", b_out, 8'h66);
      cyc();

      // R7: B-to-A mirror, A-to-B left holding
      set_ba(0, 0, 0);
      b_in = 8'hE1; cyc();
      b_in = 8'h1E; cyc();
      set_ba(0, 1, 0); b_in = 8'h55;
      #2 chk(a_out === 8'h1E, "R7 B-to-A capture", a_out, 8'h1E);
      chk(b_out === 8'h66, "R7 A-to-B untouched", b_out, 8'h66);
      cyc();
      set_ba(1, 0, 0); cyc();

      // R8: both directions driving
      set_ab(0, 0, 0); set_ba(0, 0, 0); a_in = 8'h0F; b_in = 8'hF0; cyc();
      set_ba(0, 0, 1); cyc();

      // R1: reset mid-run
      rst = 1'b1; cyc();
      rst = 1'b0; set_ab(0, 1, 0); set_ba(0, 1, 0); a_in = 8'hAA; b_in = 8'hBB;
      #2 chk(b_out === 8'h00, "R1 mid-run reset", b_out, 8'h00);
      chk(a_out === 8'h00, "R1 mid-run reset", a_out, 8'h00);
      cyc();

      // Pseudo-random control and data mix
      lfsr = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         set_ab(lfsr[0] & lfsr[5], lfsr[1], lfsr[2]);
         set_ba(lfsr[3] & lfsr[6], lfsr[4], lfsr[7]);
         a_in = lfsr[15:8] ^ 8'h5C;
         b_in = lfsr[7:0] ^ lfsr[15:8];
         cyc();
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule